// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block sits between the internal bus and external memory. It decides which of four programmable memory regions a bus cycle targets. Each region has two words of configuration: a base word and an option word. When a transfer starts, the block masks the upper address bits and the address type and compares them with every region. It then opens a cycle for the winning region. That cycle holds the region's chip select, reports the region's port width and strobe mode, and drives the burst-inhibit line.

The block counts the wait states of the region and returns the transfer acknowledge itself. If the region hands acknowledge to external logic, the block waits for the external acknowledge input instead. For burst reads it shapes the burst-data-in-progress strobe in one of three ways: normal, late, or per-beat toggling. A write to a write-protected region is refused. In that case no select and no acknowledge are given, a one-cycle transfer-error pulse is raised, and a sticky error flag is set.

Top module: `bank_select`

## Requirements
- R1: A region matches when `bus_addr` equals the base field (base word bits 16:0) on every bit enabled in the address mask (option word bits 16:0). `bus_type` must also equal the type field (base bits 19:17) on every bit enabled in the type mask (option bits 19:17). A match drives that region's `cs` bit from the first cycle after `bus_start` is sampled.
- R2: A region whose valid bit (base bit 27) is clear never asserts its chip select.
- R3: If several valid regions match, the lowest-numbered one wins. `cs` is never more than one-hot. An access that matches no region asserts no chip select.
- R4: While a cycle is open, `port_size` shows the region's width code and `strobe_be` shows its strobe-mode bit. The width code sits in base bits 21:20: 00 means 32-bit, 01 means 8-bit, 10 means 16-bit and 11 is reserved. The strobe-mode bit is base bit 23, where 1 means byte selects.
- R5: A write to a region with write protect set (base bit 22) asserts neither `cs` nor `ack`. It pulses `tea` for one cycle and sets `wp_err`, which stays set until reset. Reads of that region proceed normally.
- R6: When a region's burst-inhibit bit (option bit 24) is set, `burst_inh_n` is low while its cycle is open, and a burst request completes as a single beat. When the bit is clear, `burst_inh_n` stays high.
- R7: Let N be the wait-state field (option bits 23:20). With internal acknowledge, `ack` is high in cycle N of the access, counting the first `cs` cycle as cycle 0. A single access closes after that edge.
- R8: When external acknowledge is selected (base bit 26), `ack` stays low. The cycle closes on the edge where `ext_ack` is sampled high.
- R9: A burst runs BEATS beats (default 4), with one beat acknowledged per cycle after the first. With normal timing, `burst_dip` is high from cycle 1 up to the cycle before the last beat, and low in the last-beat cycle.
- R10: With late timing (base bit 25), `burst_dip` first rises in cycle max(1,N). Late timing overrides the toggle bit when both are set.
- R11: With toggle timing (base bit 24) and late timing clear, `burst_dip` is high only in cycles that acknowledge an even-numbered, non-final beat.
- R12: After reset, region 0 has burst inhibit set and its valid bit copied from `boot_valid`. Every other field is zero. The outputs are idle: `cs`=0, `burst_inh_n`=1, `tea`=0, `wp_err`=0.
- R13: A `bus_start` that arrives while a cycle is open is ignored. It changes neither the open cycle nor its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_valid | input | 1 | Reset value of region 0 valid bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | IW | Region selected for the write |
| cfg_opt | input | 1 | 1 writes option word, 0 writes base word |
| cfg_wdata | input | CFG_W (28) | Configuration word |
| bus_start | input | 1 | Transfer start |
| bus_addr | input | AW (17) | Upper address bits compared |
| bus_type | input | TW (3) | Address type |
| bus_write | input | 1 | 1 = write |
| bus_burst | input | 1 | Burst requested |
| ext_ack | input | 1 | Acknowledge from external logic |
| cs | output | NREG | Chip selects, active high |
| port_size | output | 2 | Width code of the open region |
| strobe_be | output | 1 | Strobes act as byte selects |
| burst_inh_n | output | 1 | Burst inhibit, active low |
| ack | output | 1 | Internal transfer acknowledge |
| burst_dip | output | 1 | Burst data in progress |
| tea | output | 1 | Transfer error pulse |
| wp_err | output | 1 | Sticky write-protect error |

## Verification
The bench programs two overlapping regions to probe priority. A design that ignored ordering would select the higher region or several at once. It checks the wait-state count exactly at its boundary cycle, where an off-by-one counter moves `ack` or closes the cycle early. The three strobe timings are compared cycle by cycle. A toggle mode that did not alternate, or a late mode that lost to toggle, shows a wrong `burst_dip` in a specific cycle. The bench also sends a second start in the middle of an open cycle and a protected write. A design that restarted, extended the cycle, or let the write through would show `cs` or `ack` at the wrong time or a missing `tea`.

// File: rtl/bank_select_pkg.sv
package bank_select_pkg;
    parameter int AW  = 17;  // compared address bits
    parameter int TW  = 3;   // address type bits
    parameter int WSW = 4;   // wait-state field bits

    typedef struct packed {
        logic           valid;
        logic           ext;
        logic           late;
        logic           toggle;
        logic           be;
        logic           wprot;
        logic [1:0]     psize;
        logic [TW-1:0]  atype;
        logic [AW-1:0]  base;
    } base_t;

    typedef struct packed {
        logic           binh;
        logic [WSW-1:0] waits;
        logic [TW-1:0]  tmask;
        logic [AW-1:0]  amask;
    } opt_t;

    // Per-region attributes needed once a cycle is accepted
    typedef struct packed {
        logic           wprot;
        logic           ext;
        logic           late;
        logic           toggle;
        logic           be;
        logic           binh;
        logic [1:0]     psize;
        logic [WSW-1:0] waits;
    } prof_t;

    localparam int CFG_W = $bits(base_t);
endpackage

// File: rtl/bank_regs.sv
module bank_regs
    import bank_select_pkg::*;
#(
    parameter int NREG = 4,
    localparam int IW = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boot_valid,
    input  logic                  cfg_we,
    input  logic [IW-1:0]         cfg_sel,
    input  logic                  cfg_opt,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output base_t [NREG-1:0]      base_q,
    output opt_t  [NREG-1:0]      opt_q
);
    typedef struct packed {
        base_t [NREG-1:0] base;
        opt_t  [NREG-1:0] opt;
    } regs_t;

    regs_t r_d, r_q, r_rst;

    always_comb begin
        r_rst                  = '0;
        r_rst.base[0].valid    = boot_valid;
        r_rst.opt[0].binh      = 1'b1;
        r_d = r_q;
        if (cfg_we) begin
            if (cfg_opt) r_d.opt[cfg_sel]  = opt_t'(cfg_wdata[$bits(opt_t)-1:0]);
            else         r_d.base[cfg_sel] = base_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= r_rst;
        else        r_q <= r_d;
    end

    assign base_q = r_q.base;
    assign opt_q  = r_q.opt;
endmodule

// File: rtl/bank_match.sv
module bank_match
    import bank_select_pkg::*;
#(
    parameter int NREG = 4,
    localparam int IW = $clog2(NREG)
) (
    input  base_t [NREG-1:0] base_q,
    input  opt_t  [NREG-1:0] opt_q,
    input  logic [AW-1:0]    addr,
    input  logic [TW-1:0]    atype,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output prof_t            prof
);
    logic [NREG-1:0] hv;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hv[g] = base_q[g].valid
                    && (((addr  ^ base_q[g].base)  & opt_q[g].amask) == '0)
                    && (((atype ^ base_q[g].atype) & opt_q[g].tmask) == '0);
    end

    // Scan downward so the lowest matching index is the last one kept
    always_comb begin
        hit_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hv[i]) hit_idx = IW'(i);
        end
        hit = |hv;
    end

    always_comb begin
        prof.wprot  = base_q[hit_idx].wprot;
        prof.ext    = base_q[hit_idx].ext;
        prof.late   = base_q[hit_idx].late;
        prof.toggle = base_q[hit_idx].toggle;
        prof.be     = base_q[hit_idx].be;
        prof.psize  = base_q[hit_idx].psize;
        prof.binh   = opt_q[hit_idx].binh;
        prof.waits  = opt_q[hit_idx].waits;
    end
endmodule

// File: rtl/bank_cycle.sv
module bank_cycle
    import bank_select_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int BEATS = 4,
    localparam int IW = $clog2(NREG),
    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          write,
    input  logic          burst,
    input  logic          ext_ack_in,
    input  logic          hit,
    input  logic [IW-1:0] hit_idx,
    input  prof_t         prof,
    output logic          active,
    output logic [IW-1:0] idx,
    output logic [1:0]    psize,
    output logic          be,
    output logic          binh,
    output logic          ack,
    output logic          dip,
    output logic          tea,
    output logic          wp_err
);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    typedef struct packed {
        logic           active;
        logic [IW-1:0]  idx;
        prof_t          p;
        logic           burst_ok;
        logic [WSW-1:0] cnt;
        logic [WSW-1:0] el;
        logic [BW-1:0]  beat;
        logic           tea;
        logic           wp_err;
    } cyc_t;

    cyc_t s_d, s_q;
    logic waits_done, beat_done, last_beat, first_ok, late_ok;

    always_comb begin
        waits_done = (s_q.cnt == s_q.p.waits);
        beat_done  = s_q.p.ext ? ext_ack_in : waits_done;
        last_beat  = !s_q.burst_ok || (s_q.beat == LAST);
        first_ok   = (s_q.el != '0);
        late_ok    = first_ok && (s_q.el >= s_q.p.waits);

        s_d     = s_q;
        s_d.tea = 1'b0;
        if (!s_q.active) begin
            if (start && hit) begin
                if (write && prof.wprot) begin
                    s_d.tea    = 1'b1;
                    s_d.wp_err = 1'b1;
                end else begin
                    s_d.active   = 1'b1;
                    s_d.idx      = hit_idx;
                    s_d.p        = prof;
                    s_d.burst_ok = burst && !prof.binh;
                    s_d.cnt      = '0;
                    s_d.el       = '0;
                    s_d.beat     = '0;
                end
            end
        end else begin
            if (!waits_done)  s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.el != '1) s_d.el  = s_q.el + 1'b1;
            if (beat_done) begin
                if (last_beat) s_d.active = 1'b0;
                else           s_d.beat   = s_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        active = s_q.active;
        idx    = s_q.idx;
        psize  = s_q.active ? s_q.p.psize : 2'b00;
        be     = s_q.active && s_q.p.be;
        binh   = s_q.active && s_q.p.binh;
        ack    = s_q.active && !s_q.p.ext && waits_done;
        tea    = s_q.tea;
        wp_err = s_q.wp_err;
        dip    = 1'b0;
        if (s_q.active && s_q.burst_ok && !last_beat) begin
            if (s_q.p.late)        dip = late_ok;
            else if (s_q.p.toggle) dip = first_ok && waits_done && !s_q.beat[0];
            else                   dip = first_ok;
        end
    end

    // R5
    sticky_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_err |=> wp_err);
    // R5
    tea_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tea |-> !active);
    // R7
    single_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !s_q.burst_ok) |=> !active);
    // R13
    hold_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !beat_done) |=> (active && $stable(idx)));
endmodule

// File: rtl/bank_select.sv
module bank_select
    import bank_select_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int BEATS = 4,
    localparam int IW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_valid,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_sel,
    input  logic             cfg_opt,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             bus_start,
    input  logic [AW-1:0]    bus_addr,
    input  logic [TW-1:0]    bus_type,
    input  logic             bus_write,
    input  logic             bus_burst,
    input  logic             ext_ack,
    output logic [NREG-1:0]  cs,
    output logic [1:0]       port_size,
    output logic             strobe_be,
    output logic             burst_inh_n,
    output logic             ack,
    output logic             burst_dip,
    output logic             tea,
    output logic             wp_err
);
    base_t [NREG-1:0] base_q;
    opt_t  [NREG-1:0] opt_q;
    logic             hit, active, binh;
    logic [IW-1:0]    hit_idx, idx;
    prof_t            prof;

    bank_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_valid(boot_valid),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_opt(cfg_opt),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .opt_q(opt_q)
    );

    bank_match #(.NREG(NREG)) u_match (
        .base_q(base_q), .opt_q(opt_q), .addr(bus_addr), .atype(bus_type),
        .hit(hit), .hit_idx(hit_idx), .prof(prof)
    );

    bank_cycle #(.NREG(NREG), .BEATS(BEATS)) u_cycle (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .write(bus_write),
        .burst(bus_burst), .ext_ack_in(ext_ack), .hit(hit), .hit_idx(hit_idx),
        .prof(prof), .active(active), .idx(idx), .psize(port_size),
        .be(strobe_be), .binh(binh), .ack(ack), .dip(burst_dip),
        .tea(tea), .wp_err(wp_err)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_cs
        assign cs[g] = active && (idx == IW'(g));
    end

    assign burst_inh_n = !binh;

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));
    // R9
    dip_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_dip |-> (cs != '0));
    // R6
    inhibit_no_dip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_inh_n |-> !burst_dip);
    // R7
    ack_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cs != '0));
endmodule

// File: tb/bank_select_bench.sv
module bank_select_bench;
    import bank_select_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             boot_valid = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic             cfg_opt = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             bus_start = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [TW-1:0]    bus_type = '0;
    logic             bus_write = 1'b0;
    logic             bus_burst = 1'b0;
    logic             ext_ack = 1'b0;
    logic [3:0]       cs;
    logic [1:0]       port_size;
    logic             strobe_be, burst_inh_n, ack, burst_dip, tea, wp_err;

    bank_select u_bank_select (
        .clk(clk), .rst_n(rst_n), .boot_valid(boot_valid), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_opt(cfg_opt), .cfg_wdata(cfg_wdata),
        .bus_start(bus_start), .bus_addr(bus_addr), .bus_type(bus_type),
        .bus_write(bus_write), .bus_burst(bus_burst), .ext_ack(ext_ack),
        .cs(cs), .port_size(port_size), .strobe_be(strobe_be),
        .burst_inh_n(burst_inh_n), .ack(ack), .burst_dip(burst_dip),
        .tea(tea), .wp_err(wp_err)
    );

    always #5 clk = ~clk;

    typedef enum int {K_CS, K_ACK, K_DIP, K_TEA, K_WPE, K_BIN, K_PS, K_BE} kind_e;
    typedef struct {
        int    at;
        kind_e k;
        int    val;
        string req;
    } item_t;

    item_t q[$];
    int cyc = 0, n_chk = 0, n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops every expectation due in this cycle and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            item_t it;
            int act;
            it = q.pop_front();
            case (it.k)
                K_CS:    act = int'(cs);
                K_ACK:   act = int'(ack);
                K_DIP:   act = int'(burst_dip);
                K_TEA:   act = int'(tea);
                K_WPE:   act = int'(wp_err);
                K_BIN:   act = int'(burst_inh_n);
                K_PS:    act = int'(port_size);
                default: act = int'(strobe_be);
            endcase
            n_chk++;
            if (it.at != cyc || act != it.val) begin
                n_fail++;
                $display("FAIL %s %s cycle %0d: actual %0d expected %0d",
                         it.req, it.k.name(), it.at, act, it.val);
            end
        end
    end

    task automatic exp(input int at, input kind_e k, input int v, input string req);
        q.push_back('{at, k, v, req});
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [CFG_W-1:0] mk_base(input logic v, ex, lt, tg, be, wp,
            input logic [1:0] ps, input logic [2:0] at, input logic [16:0] b);
        return {v, ex, lt, tg, be, wp, ps, at, b};
    endfunction

    function automatic logic [CFG_W-1:0] mk_opt(input logic bi, input logic [3:0] ws,
            input logic [2:0] tm, input logic [16:0] am);
        return {3'b000, bi, ws, tm, am};
    endfunction

    task automatic wr(input int r, input logic opt, input logic [CFG_W-1:0] d);
        cfg_sel = 2'(r); cfg_opt = opt; cfg_wdata = d; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    // Driver: raise start now; returns the cycle index of the first open cycle
    task automatic go(input logic [16:0] a, input logic [2:0] t, input logic w,
                      input logic b, output int base);
        bus_addr = a; bus_type = t; bus_write = w; bus_burst = b; bus_start = 1'b1;
        base = cyc + 1;
    endtask

    task automatic drop();
        tick();
        bus_start = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int b, dummy;
        idle(3);
        rst_n = 1'b1;
        // R12 reset state
        exp(cyc + 1, K_CS, 0, "R12");  exp(cyc + 1, K_WPE, 0, "R12");
        exp(cyc + 1, K_TEA, 0, "R12"); exp(cyc + 1, K_BIN, 1, "R12");
        idle(2);
        // R12 region 0 valid from boot, burst inhibit set, zero masks
        go(17'h1ABCD, 3'd5, 1'b0, 1'b0, b);
        exp(b, K_CS, 1, "R12"); exp(b, K_BIN, 0, "R12"); exp(b, K_ACK, 1, "R7");
        exp(b + 1, K_CS, 0, "R7");
        drop(); idle(3);

        wr(0, 1'b0, '0);
        wr(1, 1'b0, mk_base(1, 0, 0, 0, 0, 0, 2'b01, 3'd1, 17'h00100));
        wr(1, 1'b1, mk_opt(0, 4'd3, 3'b111, 17'h1FF00));
        wr(2, 1'b0, mk_base(1, 0, 0, 0, 1, 0, 2'b10, 3'd1, 17'h00100));
        wr(2, 1'b1, mk_opt(0, 4'd1, 3'b111, 17'h1FF00));
        wr(3, 1'b0, mk_base(0, 0, 0, 0, 0, 1, 2'b00, 3'd0, 17'h02000));
        wr(3, 1'b1, mk_opt(0, 4'd0, 3'b000, 17'h1FFFF));

        // R1 R4 R7 masked match, width code, wait states
        go(17'h00123, 3'd1, 1'b0, 1'b0, b);
        exp(b, K_CS, 2, "R1"); exp(b, K_PS, 1, "R4"); exp(b, K_BE, 0, "R4");
        exp(b, K_ACK, 0, "R7"); exp(b + 2, K_ACK, 0, "R7");
        exp(b + 3, K_ACK, 1, "R7"); exp(b + 3, K_CS, 2, "R7");
        exp(b + 4, K_CS, 0, "R7");
        drop(); idle(6);

        // R1 type mismatch, then address mismatch
        go(17'h00123, 3'd2, 1'b0, 1'b0, b);
        exp(b, K_CS, 0, "R1");
        drop(); idle(2);
        go(17'h00223, 3'd1, 1'b0, 1'b0, b);
        exp(b, K_CS, 0, "R1");
        drop(); idle(2);

        // R2 invalid region, then validated (write protected, read allowed)
        go(17'h02000, 3'd1, 1'b0, 1'b0, b);
        exp(b, K_CS, 0, "R2");
        drop(); idle(2);
        wr(3, 1'b0, mk_base(1, 0, 0, 0, 0, 1, 2'b00, 3'd0, 17'h02000));
        go(17'h02000, 3'd1, 1'b0, 1'b0, b);
        exp(b, K_CS, 8, "R2"); exp(b, K_TEA, 0, "R5"); exp(b + 1, K_CS, 0, "R2");
        drop(); idle(3);

        // R5 protected write
        go(17'h02000, 3'd1, 1'b1, 1'b0, b);
        exp(b, K_CS, 0, "R5"); exp(b, K_TEA, 1, "R5"); exp(b, K_WPE, 1, "R5");
        exp(b, K_ACK, 0, "R5");
        exp(b + 1, K_TEA, 0, "R5"); exp(b + 1, K_CS, 0, "R5");
        exp(b + 5, K_WPE, 1, "R5");
        drop(); idle(6);

        // R3 overlap: lowest index wins
        go(17'h00155, 3'd1, 1'b0, 1'b0, b);
        exp(b, K_CS, 2, "R3"); exp(b + 4, K_CS, 0, "R3");
        drop(); idle(5);
        wr(1, 1'b0, mk_base(0, 0, 0, 0, 0, 0, 2'b01, 3'd1, 17'h00100));
        go(17'h00155, 3'd1, 1'b0, 1'b0, b);
        exp(b, K_CS, 4, "R3"); exp(b, K_PS, 2, "R4"); exp(b, K_BE, 1, "R4");
        exp(b + 1, K_ACK, 1, "R7"); exp(b + 2, K_CS, 0, "R7");
        drop(); idle(3);

        // R6 burst inhibit refuses burst
        wr(3, 1'b1, mk_opt(1, 4'd0, 3'b000, 17'h1FFFF));
        go(17'h02000, 3'd1, 1'b0, 1'b1, b);
        exp(b, K_CS, 8, "R6"); exp(b, K_BIN, 0, "R6"); exp(b, K_ACK, 1, "R6");
        exp(b, K_DIP, 0, "R6");
        exp(b + 1, K_CS, 0, "R6"); exp(b + 1, K_DIP, 0, "R6"); exp(b + 1, K_BIN, 1, "R6");
        drop(); idle(3);

        // R9 normal strobe, waits 1
        go(17'h00100, 3'd1, 1'b0, 1'b1, b);
        exp(b, K_DIP, 0, "R9"); exp(b, K_BIN, 1, "R6");
        exp(b + 1, K_DIP, 1, "R9"); exp(b + 1, K_ACK, 1, "R9");
        exp(b + 2, K_DIP, 1, "R9");
        exp(b + 4, K_DIP, 0, "R9"); exp(b + 4, K_ACK, 1, "R9");
        exp(b + 5, K_CS, 0, "R9");
        drop(); idle(7);

        // R10 late strobe, waits 3
        wr(2, 1'b1, mk_opt(0, 4'd3, 3'b111, 17'h1FF00));
        wr(2, 1'b0, mk_base(1, 0, 1, 0, 1, 0, 2'b10, 3'd1, 17'h00100));
        go(17'h00100, 3'd1, 1'b0, 1'b1, b);
        exp(b + 2, K_DIP, 0, "R10"); exp(b + 3, K_DIP, 1, "R10");
        exp(b + 3, K_ACK, 1, "R10"); exp(b + 6, K_DIP, 0, "R10");
        exp(b + 7, K_CS, 0, "R10");
        drop(); idle(9);

        // R11 toggle strobe
        wr(2, 1'b0, mk_base(1, 0, 0, 1, 1, 0, 2'b10, 3'd1, 17'h00100));
        go(17'h00100, 3'd1, 1'b0, 1'b1, b);
        exp(b + 1, K_DIP, 0, "R11"); exp(b + 3, K_DIP, 1, "R11");
        exp(b + 4, K_DIP, 0, "R11"); exp(b + 5, K_DIP, 1, "R11");
        exp(b + 6, K_DIP, 0, "R11"); exp(b + 7, K_CS, 0, "R11");
        drop(); idle(9);

        // R10 late overrides toggle
        wr(2, 1'b0, mk_base(1, 0, 1, 1, 1, 0, 2'b10, 3'd1, 17'h00100));
        go(17'h00100, 3'd1, 1'b0, 1'b1, b);
        exp(b + 3, K_DIP, 1, "R10"); exp(b + 4, K_DIP, 1, "R10");
        exp(b + 5, K_DIP, 1, "R10");
        drop(); idle(9);

        // R8 external acknowledge
        wr(1, 1'b0, mk_base(1, 1, 0, 0, 0, 0, 2'b01, 3'd1, 17'h00100));
        go(17'h00100, 3'd1, 1'b0, 1'b0, b);
        exp(b, K_CS, 2, "R8"); exp(b + 3, K_ACK, 0, "R8"); exp(b + 3, K_CS, 2, "R8");
        exp(b + 5, K_CS, 2, "R8"); exp(b + 6, K_CS, 0, "R8");
        drop(); idle(5);
        ext_ack = 1'b1;
        tick();
        ext_ack = 1'b0;
        idle(3);

        // R13 second start during an open cycle is ignored
        wr(1, 1'b0, mk_base(1, 0, 0, 0, 0, 0, 2'b01, 3'd1, 17'h00100));
        go(17'h00100, 3'd1, 1'b0, 1'b0, b);
        exp(b, K_CS, 2, "R13"); exp(b + 1, K_CS, 2, "R13"); exp(b + 2, K_CS, 2, "R13");
        exp(b + 3, K_ACK, 1, "R13"); exp(b + 4, K_CS, 0, "R13");
        exp(b + 5, K_CS, 0, "R13");
        drop();
        go(17'h02000, 3'd1, 1'b0, 1'b0, dummy);
        drop();
        idle(8);

        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 scoreboard: actual %0d pending expected 0", q.size());
        end
        summary();
        $finish;
    end
endmodule